// File: doc/BRIEF.md
# DRAM activate timing tracker

This block sits beside the command scheduler of a DRAM controller. Each DRAM clock the scheduler presents one candidate rank and bank. The block answers with two flags: whether an activate to that bank may issue now, and whether a precharge or precharge-all to that rank may issue now. The scheduler reports each command it actually issues through a strobe with a type, a rank and a bank. The block keeps saturating elapsed-time counters per rank and per bank from these reports.

Every spacing limit is read from one packed 32-bit configuration word and counted in DRAM clocks. The rules cover precharge to precharge on a rank, activate to activate on a rank, precharge to activate on a bank, and precharge-all to activate on a rank. A rolling window admits at most four activates per rank, and one configuration bit switches that window off. A command issued in cycle t with a limit of N lets a candidate in cycle t+k through when k >= N. Grants are combinational from the stored state and the candidate inputs. A command issued in a cycle therefore affects the grants from the following cycle on.

Top module: `act_timing_tracker`

## Requirements
- R1: After reset, both grant flags are 1 for every rank and bank, whatever the configuration word holds.
- R2: Issue command codes are 0 for none, 1 for activate, 2 for precharge and 3 for precharge-all. grant_pre_o is 0 until cfg_i[31:28] cycles have passed since the last precharge or precharge-all to the candidate rank.
- R3: grant_act_o is 0 until cfg_i[20:17] cycles have passed since the last activate to the candidate rank.
- R4: grant_act_o is 0 until cfg_i[16:13] cycles have passed since the last precharge to the candidate rank and bank. A precharge-all counts as a precharge to every bank of its rank, and a precharge to another bank has no effect.
- R5: grant_act_o is 0 until cfg_i[12:9] cycles have passed since the last precharge-all to the candidate rank.
- R6: When cfg_i[21] is 0, grant_act_o is 0 until cfg_i[27:22] cycles have passed since the oldest of the last four activates to the candidate rank.
- R7: When cfg_i[21] is 1, the four-activate window never blocks an activate.
- R8: A limit of zero never blocks. Commands to one rank never change the grants of the other rank.
- R9: Elapsed counts saturate at 63, so after any long idle period every limit up to its field maximum is met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DRAM clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 32 | Packed timing configuration word |
| issue_vld_i | input | 1 | A command issued this cycle |
| issue_cmd_i | input | 2 | Issued command type (0 none, 1 ACT, 2 PRE, 3 PRE-ALL) |
| issue_rank_i | input | 1 | Rank of the issued command |
| issue_bank_i | input | 3 | Bank of the issued command (ignored for PRE-ALL) |
| cand_rank_i | input | 1 | Candidate rank |
| cand_bank_i | input | 3 | Candidate bank |
| grant_act_o | output | 1 | An activate to the candidate bank may issue now |
| grant_pre_o | output | 1 | A precharge or precharge-all to the candidate rank may issue now |

## Verification
A cycle-by-cycle vector walk mixes activates, precharges and a precharge-all on one rank, with the candidate moved between banks and ranks. This shows which rule releases each grant, and that another bank or rank is left alone. Four back-to-back activates measure the window edge to the exact cycle, and the same burst with the disable bit set shows the window is off. Widely spaced activates at the largest field values, followed by a long idle stretch, tell a saturating count apart from a wrapping one. A reset taken while everything is blocked shows that all history is cleared.

// File: rtl/act_trk_pkg.sv
package act_trk_pkg;
  typedef enum logic [1:0] {
    CMD_NOP    = 2'd0,
    CMD_ACT    = 2'd1,
    CMD_PRE    = 2'd2,
    CMD_PREALL = 2'd3
  } cmd_e;

  // field positions are fixed by the configuration word
  typedef struct packed {
    logic [3:0] pre_pre;
    logic [5:0] win_len;
    logic       win_off;
    logic [3:0] act_act;
    logic [3:0] pre_act;
    logic [3:0] preall_act;
    logic [6:0] rsvd;
    logic [1:0] spare;
  } cfg_t;
endpackage

// File: rtl/trk_sat_cnt.sv
module trk_sat_cnt #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  // elapsed cycles since last event; reset reads as "long ago"
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_o <= MAX;
    else if (clr_i)         cnt_o <= W'(1);
    else if (cnt_o != MAX)  cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_HOLD_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == MAX && !clr_i) |=> (cnt_o == MAX)); // R9
  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == W'(1))); // R3
endmodule

// File: rtl/trk_act_window.sv
module trk_act_window #(
  parameter int W     = 6,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         act_i,
  input  logic [W-1:0] win_len_i,
  input  logic         win_off_i,
  output logic         ok_o
);
  localparam logic [W-1:0] MAX = '1;

  logic [W-1:0] age_q [DEPTH];

  function automatic logic [W-1:0] inc_sat(input logic [W-1:0] v);
    return (v == MAX) ? v : v + 1'b1;
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    age_q[i] <= MAX;
      else if (act_i) age_q[i] <= (i == 0) ? W'(1) : inc_sat(age_q[(i == 0) ? 0 : i-1]);
      else            age_q[i] <= inc_sat(age_q[i]);
    end
    if (i > 0) begin : g_ord
      AST_WIN_AGE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
        age_q[i] >= age_q[i-1]); // R6
    end
  end

  // oldest of the last DEPTH activates must be out of the window
  assign ok_o = win_off_i || (age_q[DEPTH-1] >= win_len_i);
endmodule

// File: rtl/act_timing_tracker.sv
module act_timing_tracker
  import act_trk_pkg::*;
#(
  parameter int NUM_RANKS = 2,
  parameter int NUM_BANKS = 8,
  parameter int WIN_DEPTH = 4,
  parameter int CNT_W     = 6,
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       cfg_i,
  input  logic              issue_vld_i,
  input  logic [1:0]        issue_cmd_i,
  input  logic [RANK_W-1:0] issue_rank_i,
  input  logic [BANK_W-1:0] issue_bank_i,
  input  logic [RANK_W-1:0] cand_rank_i,
  input  logic [BANK_W-1:0] cand_bank_i,
  output logic              grant_act_o,
  output logic              grant_pre_o
);
  cfg_t cfg;
  cmd_e cmd;
  assign cfg = cfg_t'(cfg_i);
  assign cmd = cmd_e'(issue_cmd_i);

  logic unused_cfg;
  assign unused_cfg = ^{cfg.rsvd, cfg.spare};

  logic [CNT_W-1:0] pp_cnt [NUM_RANKS];
  logic [CNT_W-1:0] aa_cnt [NUM_RANKS];
  logic [CNT_W-1:0] pa_cnt [NUM_RANKS];
  logic [CNT_W-1:0] bk_cnt [NUM_RANKS][NUM_BANKS];
  logic             win_ok [NUM_RANKS];

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    logic hit, is_act, is_pre, is_all;
    assign hit    = issue_vld_i && (issue_rank_i == RANK_W'(r));
    assign is_act = hit && (cmd == CMD_ACT);
    assign is_pre = hit && (cmd == CMD_PRE);
    assign is_all = hit && (cmd == CMD_PREALL);

    trk_sat_cnt #(.W(CNT_W)) i_pp (
      .clk_i, .rst_ni, .clr_i(is_pre || is_all), .cnt_o(pp_cnt[r]));
    trk_sat_cnt #(.W(CNT_W)) i_aa (
      .clk_i, .rst_ni, .clr_i(is_act), .cnt_o(aa_cnt[r]));
    trk_sat_cnt #(.W(CNT_W)) i_pa (
      .clk_i, .rst_ni, .clr_i(is_all), .cnt_o(pa_cnt[r]));

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      trk_sat_cnt #(.W(CNT_W)) i_bk (
        .clk_i, .rst_ni,
        .clr_i(is_all || (is_pre && (issue_bank_i == BANK_W'(b)))),
        .cnt_o(bk_cnt[r][b]));
    end

    trk_act_window #(.W(CNT_W), .DEPTH(WIN_DEPTH)) i_win (
      .clk_i, .rst_ni, .act_i(is_act),
      .win_len_i(CNT_W'(cfg.win_len)), .win_off_i(cfg.win_off),
      .ok_o(win_ok[r]));
  end

  assign grant_pre_o = pp_cnt[cand_rank_i] >= CNT_W'(cfg.pre_pre);
  assign grant_act_o = (aa_cnt[cand_rank_i] >= CNT_W'(cfg.act_act))
                    && (bk_cnt[cand_rank_i][cand_bank_i] >= CNT_W'(cfg.pre_act))
                    && (pa_cnt[cand_rank_i] >= CNT_W'(cfg.preall_act))
                    && win_ok[cand_rank_i];

  AST_PRE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_vld_i && (cmd == CMD_PRE || cmd == CMD_PREALL) && cfg.pre_pre > 4'd1)
    |=> (cand_rank_i != $past(issue_rank_i) || cfg_i != $past(cfg_i) || !grant_pre_o)); // R2
  AST_ACT_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_vld_i && cmd == CMD_ACT && cfg.act_act > 4'd1)
    |=> (cand_rank_i != $past(issue_rank_i) || cfg_i != $past(cfg_i) || !grant_act_o)); // R3
  AST_BANK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_vld_i && cmd == CMD_PRE && cfg.pre_act > 4'd1)
    |=> (cand_rank_i != $past(issue_rank_i) || cand_bank_i != $past(issue_bank_i)
         || cfg_i != $past(cfg_i) || !grant_act_o)); // R4
  AST_ALL_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_vld_i && cmd == CMD_PREALL && cfg.preall_act > 4'd1)
    |=> (cand_rank_i != $past(issue_rank_i) || cfg_i != $past(cfg_i) || !grant_act_o)); // R5
endmodule

// File: tb/test_act_timing_tracker.sv
`timescale 1ns/1ps
module test_act_timing_tracker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] cfg_i = '0;
  logic        issue_vld_i = 1'b0;
  logic [1:0]  issue_cmd_i = 2'd0;
  logic        issue_rank_i = 1'b0;
  logic [2:0]  issue_bank_i = 3'd0;
  logic        cand_rank_i = 1'b0;
  logic [2:0]  cand_bank_i = 3'd0;
  logic        grant_act_o, grant_pre_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i; // 50 MHz

  act_timing_tracker i_act_timing_tracker (.*);

  // tag, vld, cmd, issue rank/bank, cand rank/bank, exp act, exp pre
  function automatic logic [16:0] mk(int tag, int v, int c, int ir, int ib,
                                     int cr, int cb, int ea, int ep);
    return {4'(tag), 1'(v), 2'(c), 1'(ir), 3'(ib), 1'(cr), 3'(cb), 1'(ea), 1'(ep)};
  endfunction

  localparam logic [31:0] CFG_MIX = 32'h3284_8A00; // pp3 win10 aa2 pa4 all5
  localparam int NV = 14;
  localparam logic [16:0] TBL [NV] = '{
    mk(1,0,0,0,0,0,0,1,1), mk(3,1,1,0,0,0,0,1,1), mk(3,0,0,0,0,0,1,0,1),
    mk(3,1,1,0,1,0,1,1,1), mk(8,1,2,0,0,1,0,1,1), mk(4,0,0,0,0,0,0,0,0),
    mk(4,0,0,0,0,0,2,1,0), mk(4,0,0,0,0,0,0,0,1), mk(4,1,3,0,5,0,0,1,1),
    mk(5,0,0,0,0,0,3,0,0), mk(5,0,0,0,0,0,3,0,0), mk(5,0,0,0,0,0,3,0,1),
    mk(5,0,0,0,0,0,3,0,1), mk(5,0,0,0,0,0,3,1,1)
  };

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic cyc(input int v, input int c, input int ir, input int ib,
                     input int cr, input int cb);
    @(negedge clk_i);
    issue_vld_i = 1'(v); issue_cmd_i = 2'(c);
    issue_rank_i = 1'(ir); issue_bank_i = 3'(ib);
    cand_rank_i = 1'(cr); cand_bank_i = 3'(cb);
    #1;
  endtask

  task automatic do_reset(input logic [31:0] cfg);
    @(negedge clk_i);
    issue_vld_i = 1'b0; issue_cmd_i = 2'd0;
    rst_ni = 1'b0; cfg_i = cfg;
    #5 rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // vector walk
    do_reset(CFG_MIX);
    cyc(0,0,0,0,1,7);
    chk("R1 act r1b7", grant_act_o, 1'b1);
    chk("R1 pre r1b7", grant_pre_o, 1'b1);
    for (int i = 0; i < NV; i++) begin
      logic [16:0] e;
      e = TBL[i];
      cyc(int'(e[12]), int'(e[11:10]), int'(e[9]), int'(e[8:6]), int'(e[5]), int'(e[4:2]));
      chk($sformatf("R%0d act vec%0d", e[16:13], i), grant_act_o, e[1]);
      chk($sformatf("%s pre vec%0d", (i == 0) ? "R1" : "R2", i), grant_pre_o, e[0]);
    end

    // window edge: four ACTs at k=0..3, window 10
    do_reset(32'h0282_0000);
    for (int k = 0; k < 4; k++) cyc(1,1,0,0,0,0);
    cyc(0,0,0,0,1,0);
    chk("R8 other rank open", grant_act_o, 1'b1);
    for (int k = 5; k <= 10; k++) begin
      cyc(0,0,0,0,0,0);
      chk($sformatf("R6 window k=%0d", k), grant_act_o, 1'(k >= 10));
    end

    // window disabled
    do_reset(32'h02A2_0000);
    for (int k = 0; k < 4; k++) cyc(1,1,0,0,0,0);
    cyc(0,0,0,0,0,0);
    chk("R7 window off", grant_act_o, 1'b1);

    // all limits zero
    do_reset(32'h0000_0000);
    for (int k = 0; k < 4; k++) cyc(1,1,0,0,0,0);
    cyc(1,2,0,0,0,0);
    chk("R8 zero act", grant_act_o, 1'b1);
    cyc(0,0,0,0,0,0);
    chk("R8 zero pre", grant_pre_o, 1'b1);

    // saturation: aa15, window 63, ACTs at k=0,15,30,45
    do_reset(32'h0FDE_0000);
    for (int k = 0; k <= 200; k++) begin
      if (k == 0 || k == 15 || k == 30 || k == 45) cyc(1,1,0,0,0,0);
      else cyc(0,0,0,0,0,0);
      if (k == 14)  chk("R3 aa15 k=14", grant_act_o, 1'b0);
      if (k == 62)  chk("R6 win63 k=62", grant_act_o, 1'b0);
      if (k == 63)  chk("R6 win63 k=63", grant_act_o, 1'b1);
      if (k == 200) chk("R9 idle k=200", grant_act_o, 1'b1);
    end

    // reset while blocked
    do_reset(32'h3282_0000);
    for (int k = 0; k < 4; k++) cyc(1,1,0,0,0,0);
    cyc(1,2,0,0,0,0);
    cyc(0,0,0,0,0,0);
    chk("R6 blocked before reset", grant_act_o, 1'b0);
    chk("R2 blocked before reset", grant_pre_o, 1'b0);
    do_reset(32'h3282_0000);
    cyc(0,0,0,0,0,0);
    chk("R1 act after reset", grant_act_o, 1'b1);
    chk("R1 pre after reset", grant_pre_o, 1'b1);

    finish_run();
  end
endmodule